// File: doc/BRIEF.md
# Banked Clock Fan-out with Per-Bank Divide and Glitch-Free Gating

This block takes one of two reference clocks and fans the chosen clock out to a number of output banks. Each bank has several outputs, and all outputs of a bank carry the same waveform. Each bank chooses on its own whether to pass the reference clock through unchanged or to halve its frequency. Each bank can also be switched on or off at any time, without producing a shortened pulse.

An active-low master reset clears every divide stage and every enable stage. While the reset is asserted, all outputs float in high impedance. Once the reset is released, the outputs are driven again, and every divided bank starts in the same phase.

A bank that is switched off drives its outputs low; it does not float them. The block is meant to sit at the clock root of a chip region. The reference select is set before reset is released and is not changed while the block runs.

Top module: `clkfan_bank_driver`

## Requirements
- R1: All outputs of one bank show the same level at every instant. Bank b owns output bits b*OUTS_PER_BANK up to b*OUTS_PER_BANK+OUTS_PER_BANK-1.
- R2: With `clk_sel` at 0, the banks are clocked from `clk_a`. With `clk_sel` at 1, they are clocked from `clk_b`.
- R3: When a bank's `div_sel` bit is 0, the bank's output period equals the reference period. When the bit is 1, the output period is twice the reference period with a 50 % duty cycle. A divided bank's internal divide stage toggles on every rising reference edge, and an undivided bank's divide stage stays low.
- R4: A change of a bank's `div_sel` bit is taken on a rising reference edge, and only when the bank's divide stage is low. The change never makes an output high or low time shorter than half a reference period.
- R5: A bank's `bank_en` bit may change at any time. It passes through a synchronizer clocked on falling reference edges, and it reaches the output gate only while the bank's clock is low. A disabled bank drives its outputs low. Toggling the enable never makes a high or low time shorter than half a reference period.
- R6: While `mrst_n` is 0, every output is high impedance, and the divide and enable stages are cleared. After `mrst_n` returns to 1, the outputs are actively driven again.
- R7: After reset is released, every divided bank rises first on the first rising reference edge, and after that on every second rising edge. As a result, all divided banks are in phase with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Reference clock used when `clk_sel` is 0 |
| clk_b | input | 1 | Reference clock used when `clk_sel` is 1 |
| clk_sel | input | 1 | Reference select; held static while the block runs |
| div_sel | input | BANKS | Per-bank divide choice: 0 passes the clock through, 1 halves it |
| bank_en | input | BANKS | Per-bank enable; may change asynchronously |
| mrst_n | input | 1 | Active-low master reset and output-float control |
| clk_out | output | BANKS*OUTS_PER_BANK | Clock outputs, grouped by bank |

## Verification
A divide stage stuck in the wrong state shows at the ports within one or two reference cycles. It appears as a bank period of the wrong length, or as a divided bank rising on an even-numbered edge counted from reset release. An enable stage that updates at the wrong moment shows up only when an enable toggles while the bank is high, as a high time shorter than half a reference period. For that reason the bench measures every pulse width during a long run of random enable and divide changes. A tri-state fault shows in the first sample taken during reset, because the pulled-up outputs then read something other than all ones.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/1ps
package clkfan_pkg;

    parameter int unsigned DEF_BANKS         = 4;
    parameter int unsigned DEF_OUTS_PER_BANK = 4;
    parameter int unsigned DEF_SYNC_STAGES   = 2;

    typedef enum logic {
        DIV_BY1 = 1'b0,
        DIV_BY2 = 1'b1
    } div_mode_e;

    typedef struct packed {
        div_mode_e mode;
        logic      div_q;
        logic      gate;
    } bank_state_t;

    // Output level of a bank for a given state and reference level.
    function automatic logic bank_level(bank_state_t st, logic ref_lvl);
        logic raw;
        raw = (st.mode == DIV_BY2) ? st.div_q : ref_lvl;
        return st.gate & raw;
    endfunction

    // A bank may change its gate or mode only while its divide stage is low.
    function automatic logic bank_quiet(bank_state_t st);
        return ~st.div_q;
    endfunction

endpackage

// File: rtl/clkfan_ref_mux.sv
`timescale 1ns/1ps
module clkfan_ref_mux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic clk_sel,
    output logic ref_clk
);
    // Static select; switching while running is not supported.
    always_comb ref_clk = clk_sel ? clk_b : clk_a;
endmodule

// File: rtl/clkfan_divider.sv
`timescale 1ns/1ps
module clkfan_divider
    import clkfan_pkg::*;
(
    input  logic      ref_clk,
    input  logic      mrst_n,
    input  logic      div_sel,
    output div_mode_e mode_q,
    output logic      div_q
);
    div_mode_e mode_d;

    // A new mode is accepted only while the divide stage is low.
    always_comb mode_d = div_q ? mode_q : div_mode_e'(div_sel);

    always_ff @(posedge ref_clk or negedge mrst_n) begin
        if (!mrst_n) begin
            mode_q <= DIV_BY1;
            div_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            div_q  <= (mode_d == DIV_BY2) ? ~div_q : 1'b0;
        end
    end
endmodule

// File: rtl/clkfan_en_sync.sv
`timescale 1ns/1ps
module clkfan_en_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic mrst_n,
    input  logic en_async,
    input  logic bank_quiet,
    output logic gate_q
);
    localparam int unsigned CHAIN = (SYNC_STAGES > 1) ? SYNC_STAGES - 1 : 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(negedge ref_clk or negedge mrst_n) begin
        if (!mrst_n) begin
            chain_q <= '0;
            gate_q  <= 1'b0;
        end else begin
            chain_q[0] <= en_async;
            for (int i = 1; i < int'(CHAIN); i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            if (bank_quiet) begin
                gate_q <= chain_q[CHAIN-1];
            end
        end
    end
endmodule

// File: rtl/clkfan_bank.sv
`timescale 1ns/1ps
module clkfan_bank
    import clkfan_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic        ref_clk,
    input  logic        mrst_n,
    input  logic        div_sel,
    input  logic        en_async,
    output bank_state_t state,
    output logic        level
);
    div_mode_e mode_q;
    logic      div_q;
    logic      gate_q;

    clkfan_divider u_div (
        .ref_clk (ref_clk),
        .mrst_n  (mrst_n),
        .div_sel (div_sel),
        .mode_q  (mode_q),
        .div_q   (div_q)
    );

    clkfan_en_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .ref_clk    (ref_clk),
        .mrst_n     (mrst_n),
        .en_async   (en_async),
        .bank_quiet (~div_q),
        .gate_q     (gate_q)
    );

    always_comb begin
        state.mode  = mode_q;
        state.div_q = div_q;
        state.gate  = gate_q;
        level       = bank_level(state, ref_clk);
    end
endmodule

// File: rtl/clkfan_bank_driver.sv
`timescale 1ns/1ps
module clkfan_bank_driver
    import clkfan_pkg::*;
#(
    parameter int unsigned BANKS         = DEF_BANKS,
    parameter int unsigned OUTS_PER_BANK = DEF_OUTS_PER_BANK,
    parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES
) (
    input  logic                             clk_a,
    input  logic                             clk_b,
    input  logic                             clk_sel,
    input  logic [BANKS-1:0]                 div_sel,
    input  logic [BANKS-1:0]                 bank_en,
    input  logic                             mrst_n,
    output logic [BANKS*OUTS_PER_BANK-1:0]   clk_out
);
    localparam int unsigned OUTS = BANKS * OUTS_PER_BANK;

    logic             ref_clk;
    logic [BANKS-1:0] bank_lvl;
    logic [BANKS-1:0] mode_vec;
    logic [BANKS-1:0] div_vec;
    logic [BANKS-1:0] gate_vec;

    clkfan_ref_mux u_mux (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .clk_sel (clk_sel),
        .ref_clk (ref_clk)
    );

    for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
        bank_state_t st;
        clkfan_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
            .ref_clk  (ref_clk),
            .mrst_n   (mrst_n),
            .div_sel  (div_sel[b]),
            .en_async (bank_en[b]),
            .state    (st),
            .level    (bank_lvl[b])
        );
        assign mode_vec[b] = st.mode;
        assign div_vec[b]  = st.div_q;
        assign gate_vec[b] = st.gate;
    end

    for (genvar o = 0; o < int'(OUTS); o++) begin : g_out
        assign clk_out[o] = mrst_n ? bank_lvl[o / OUTS_PER_BANK] : 1'bz;
    end
endmodule

// File: rtl/clkfan_chk.sv
`timescale 1ns/1ps
module clkfan_chk #(
    parameter int unsigned BANKS = 4
) (
    input logic             ref_clk,
    input logic             mrst_n,
    input logic [BANKS-1:0] mode_vec,
    input logic [BANKS-1:0] div_vec,
    input logic [BANKS-1:0] gate_vec
);
    AST_DIV2_TOGGLES: assert property (@(posedge ref_clk) disable iff (!mrst_n)
        ((mode_vec & $past(mode_vec)) & ~(div_vec ^ $past(div_vec))) == '0); // R3

    AST_DIV1_STAGE_LOW: assert property (@(posedge ref_clk) disable iff (!mrst_n)
        ((~mode_vec) & div_vec) == '0); // R3

    AST_MODE_SWITCH_QUIET: assert property (@(posedge ref_clk) disable iff (!mrst_n)
        ((mode_vec ^ $past(mode_vec)) & $past(div_vec)) == '0); // R4

    AST_GATE_SWITCH_QUIET: assert property (@(negedge ref_clk) disable iff (!mrst_n)
        ((gate_vec ^ $past(gate_vec)) & $past(div_vec)) == '0); // R5

    AST_RESET_CLEARS: assert property (@(posedge ref_clk)
        !mrst_n |-> (div_vec == '0 && gate_vec == '0)); // R6
endmodule

bind clkfan_bank_driver clkfan_chk #(.BANKS(BANKS)) chk_i (
    .ref_clk  (ref_clk),
    .mrst_n   (mrst_n),
    .mode_vec (mode_vec),
    .div_vec  (div_vec),
    .gate_vec (gate_vec)
);

// File: tb/clkfan_bank_driver_tb_top.sv
`timescale 1ns/1ps
module clkfan_bank_driver_tb_top;
    localparam int NB = 4;
    localparam int NP = 4;
    localparam int NO = NB * NP;
    localparam realtime TA = 20.0;
    localparam realtime TB = 32.0;

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          clk_sel = 1'b0;
    logic          mrst_n = 1'b0;
    logic [NB-1:0] div_sel = '0;
    logic [NB-1:0] bank_en = '0;
    tri1  [NO-1:0] clk_out;

    always #(TA/2) clk_a = ~clk_a;
    always #(TB/2) clk_b = ~clk_b;

    clkfan_bank_driver dut_i (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .clk_sel (clk_sel),
        .div_sel (div_sel),
        .bank_en (bank_en),
        .mrst_n  (mrst_n),
        .clk_out (clk_out)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic void chk(bit ok, string req, string what, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    function automatic void chk_t(bit ok, string req, string what, realtime act, realtime exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endfunction

    // ---- per-bank edge monitor ----
    logic [NB-1:0] lvl;
    logic [NB-1:0] lvl_prev = '1;
    for (genvar b = 0; b < NB; b++) begin : g_lvl
        assign lvl[b] = clk_out[b*NP];
    end

    realtime rise_t[NB];
    realtime prev_rise_t[NB];
    realtime last_edge_t[NB];
    int      rise_cnt[NB];
    bit      width_on = 1'b0;
    bit      phase_on = 1'b0;
    realtime half_t = TA/2;
    realtime ref_t  = TA;
    realtime tp0    = 0.0;

    initial begin
        for (int b = 0; b < NB; b++) begin
            rise_t[b] = 0.0; prev_rise_t[b] = 0.0; last_edge_t[b] = 0.0; rise_cnt[b] = 0;
        end
    end

    always @(lvl) begin
        realtime now;
        now = $realtime;
        for (int b = 0; b < NB; b++) begin
            if (lvl[b] !== lvl_prev[b]) begin
                if (width_on && mrst_n)  // R4 R5: no runt high or low time
                    chk_t((now - last_edge_t[b]) >= half_t - 0.01, "R5",
                          $sformatf("bank%0d pulse width", b), now - last_edge_t[b], half_t);
                last_edge_t[b] = now;
                if (lvl[b] === 1'b1) begin
                    prev_rise_t[b] = rise_t[b];
                    rise_t[b]      = now;
                    rise_cnt[b]++;
                    if (phase_on && div_sel[b]) begin : ph
                        int k;
                        k = $rtoi((now - tp0) / ref_t + 0.5);
                        chk((k % 2) == 0, "R7", $sformatf("bank%0d rise edge index parity", b), k % 2, 0);
                    end
                end
            end
        end
        lvl_prev = lvl;
    end

    // ---- scoreboard ----
    typedef struct {
        int      bank;
        realtime per;
        string   req;
    } exp_t;
    exp_t sbq[$];
    bit   mon_busy = 1'b0;

    task automatic push_period(int b, realtime p, string req);
        exp_t it;
        it.bank = b; it.per = p; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic drain();
        #1;
        wait (sbq.size() == 0 && !mon_busy);
    endtask

    initial begin
        forever begin
            exp_t it;
            int   start;
            realtime per;
            wait (sbq.size() > 0);
            mon_busy = 1'b1;
            it = sbq.pop_front();
            start = rise_cnt[it.bank];
            wait (rise_cnt[it.bank] >= start + 2);
            per = rise_t[it.bank] - prev_rise_t[it.bank];
            chk_t((per > it.per - 0.01) && (per < it.per + 0.01), it.req,
                  $sformatf("bank%0d period", it.bank), per, it.per);
            mon_busy = 1'b0;
        end
    end

    // ---- stimulus ----
    task automatic reset_window(string req);
        mrst_n = 1'b0;
        width_on = 1'b0;
        phase_on = 1'b0;
        repeat (8) begin
            #7;
            chk(clk_out === '1, req, "outputs float during reset (pulled up)", clk_out, {NO{1'b1}});
        end
    endtask

    task automatic release_on(bit sel);
        if (sel) @(negedge clk_b); else @(negedge clk_a);
        #2;
        ref_t  = sel ? TB : TA;
        half_t = ref_t / 2;
        tp0    = $realtime + half_t - 2.0;
        mrst_n   = 1'b1;
        width_on = 1'b1;
        phase_on = 1'b1;
    endtask

    task automatic random_phase(int n);
        phase_on = 1'b0;
        repeat (n) begin
            #($urandom_range(5, 60) + 0.37);
            if ($urandom_range(0, 1) == 0) bank_en[$urandom_range(0, NB-1)] ^= 1'b1;
            else                           div_sel[$urandom_range(0, NB-1)] ^= 1'b1;
        end
    endtask

    initial begin
        // Reset with select 0
        clk_sel = 1'b0; div_sel = 4'b1010; bank_en = '1;
        reset_window("R6");
        release_on(1'b0);
        repeat (4) @(posedge clk_a);

        // Driven again after release: bank0 (undivided) follows clk_a
        @(negedge clk_a); #3;
        chk(clk_out[NP-1:0] === '0, "R6", "bank0 driven low in ref low phase", clk_out[NP-1:0], 0);
        @(posedge clk_a); #3;
        chk(clk_out[NP-1:0] === '1, "R3", "bank0 high in ref high phase", clk_out[NP-1:0], {NP{1'b1}});

        // Bank outputs identical; divided banks in phase
        repeat (16) begin
            #7;
            for (int b = 0; b < NB; b++)
                chk(clk_out[b*NP +: NP] === {NP{lvl[b]}}, "R1", $sformatf("bank%0d outputs equal", b),
                    clk_out[b*NP +: NP], {NP{lvl[b]}});
            chk(lvl[1] === lvl[3], "R7", "divided banks in phase", lvl[3], lvl[1]);
        end

        for (int b = 0; b < NB; b++) push_period(b, div_sel[b] ? 2*TA : TA, "R3");
        drain();
        push_period(1, 2*TA, "R2");
        drain();
        phase_on = 1'b0;

        // Disable an undivided and a divided bank
        #3.3 bank_en[2] = 1'b0;
        #5.9 bank_en[3] = 1'b0;
        repeat (4) @(posedge clk_a);
        repeat (10) begin
            #6;
            chk(clk_out[2*NP +: NP] === '0, "R5", "disabled bank2 held low", clk_out[2*NP +: NP], 0);
            chk(clk_out[3*NP +: NP] === '0, "R5", "disabled bank3 held low", clk_out[3*NP +: NP], 0);
        end
        #5.1 bank_en[2] = 1'b1;
        #4.4 bank_en[3] = 1'b1;
        push_period(2, TA, "R5");
        push_period(3, 2*TA, "R5");
        drain();

        // Divide select change on a running bank
        #7.7 div_sel[0] = 1'b1;
        repeat (3) @(posedge clk_a);
        push_period(0, 2*TA, "R4");
        drain();
        #3.1 div_sel[1] = 1'b0;
        repeat (3) @(posedge clk_a);
        push_period(1, TA, "R4");
        drain();

        // Random enable and divide toggling, widths checked throughout
        random_phase(300);
        bank_en = '1; div_sel = 4'b0110;
        repeat (6) @(posedge clk_a);
        for (int b = 0; b < NB; b++) push_period(b, div_sel[b] ? 2*TA : TA, "R4");
        drain();

        // Second reference clock
        clk_sel = 1'b1; div_sel = 4'b0101; bank_en = '1;
        reset_window("R6");
        release_on(1'b1);
        repeat (6) @(posedge clk_b);
        for (int b = 0; b < NB; b++) push_period(b, div_sel[b] ? 2*TB : TB, "R2");
        drain();
        random_phase(150);
        bank_en = '1; div_sel = 4'b0011;
        repeat (6) @(posedge clk_b);
        for (int b = 0; b < NB; b++) push_period(b, div_sel[b] ? 2*TB : TB, "R2");
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule